// File: doc/BRIEF.md
# Four-Channel Delay-and-Sum Combiner

This block aligns four streams of signed ADC samples that arrive together on one sample clock, then adds them. Each channel runs its samples through a 64-entry circular buffer in a dual-port memory. Every accepted sample writes one entry and reads one older entry in the same cycle. The read lags the write by a per-channel delay of 0 to 63 samples. The four delayed samples are sign-extended and summed into one 12-bit word. Four 10-bit values can never overflow that width.

The delay settings for all four channels are captured together on a synchronous load strobe, so software or a steering controller can retarget the beam while samples keep flowing. Buffer entries not yet written since reset contribute zero. The output valid flag stays low until every buffer has been filled once. There is no backpressure: every sample marked valid is taken.

Top module: `dsc_combiner`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `out_sum` is 0 until the first sample is accepted.
- R2: For an accepted sample with index n (counted from 0 since reset), `out_sum` one cycle later equals the two's-complement sum of x_c[n - d_c] over the four channels, where d_c is that channel's active delay. Channel c occupies bits [10c+9:10c] of `in_samples`.
- R3: A channel with delay 0 passes the sample accepted in the same cycle into the sum, with no extra latency.
- R4: Delays range 0 to 63 (channel c in bits [6c+5:6c] of `dly_value`). The buffers wrap after 64 samples, so a delay of 63 remains exact indefinitely.
- R5: A term x_c[n - d_c] with n - d_c < 0 refers to an entry not written since reset and contributes 0.
- R6: `out_valid` is 0 for the outputs of samples 0 to 62. From sample 63 onward it is 1 one cycle after every accepted sample.
- R7: Delays change only on a cycle with `dly_load` = 1. A sample accepted in that same cycle still uses the old delays, and the new delays apply from the next sample. `dly_value` is ignored while `dly_load` = 0.
- R8: A cycle with `in_valid` = 0 writes nothing and does not advance any buffer. `out_valid` is 0 in the following cycle.
- R9: The sum never overflows: four samples of -512 give -2048, and four samples of +511 give +2044.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Shared strobe: all four samples present |
| in_samples | input | 40 | Four signed 10-bit samples, channel c at [10c+9:10c] |
| dly_load | input | 1 | Capture `dly_value` as the active delays |
| dly_value | input | 24 | Four 6-bit delays, channel c at [6c+5:6c] |
| out_sum | output | 12 | Signed sum of the four delayed samples |
| out_valid | output | 1 | `out_sum` is valid (buffers primed) |

## Verification
The bench keeps its own per-channel history of written samples. It targets the delay-0 bypass: a design that read the memory without forwarding would return the stale entry from 64 samples earlier. It checks early outputs whose delays reach before reset, where leftover memory contents or a wrong fill count would leak nonzero terms. It places a delay load on a cycle that also carries a sample, which catches designs that apply the new delay one sample early. It also exercises gaps in `in_valid`, long runs at delay 63 across the wrap, and all-minimum and all-maximum inputs. These catch pointer drift, off-by-one wrap arithmetic and a sum that is too narrow.

// File: rtl/dsc_pkg.sv
// Package: shared sizing for the delay-and-sum combiner.
// Assumes a power-of-two buffer depth so pointer arithmetic wraps naturally.
package dsc_pkg;
    localparam int CH_N      = 4;
    localparam int SMP_W     = 10;
    localparam int BUF_DEPTH = 64;
endpackage

// File: rtl/dsc_delay_line.sv
// Module: one channel's programmable delay.
// Writes each accepted sample into a circular buffer and, in the same cycle,
// reads the entry dly_q samples older into a register (one-cycle latency).
// A delay of 0 forwards the incoming sample. Entries not written since reset
// read as zero. Assumes DEPTH is a power of two.
module dsc_delay_line #(
    parameter int SMP_W = 10,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_sample,
    input  logic             dly_load,
    input  logic [PTR_W-1:0] dly_value,
    output logic [SMP_W-1:0] rd_q,
    output logic             primed
);

    logic [SMP_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] dly_q;
    logic [CNT_W-1:0] fill_cnt;
    logic [PTR_W-1:0] rd_addr;
    logic             entry_written;

    // Read address trails the write pointer by the active delay, modulo DEPTH.
    always_comb begin
        rd_addr       = wr_ptr - dly_q;
        entry_written = ({1'b0, dly_q} <= fill_cnt);
        primed        = (fill_cnt >= CNT_W'(DEPTH - 1));
    end

    // Capture a new delay only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        dly_q <= '0;
        else if (dly_load) dly_q <= dly_value;
    end

    // Advance the write pointer and the saturating fill count per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
        end else if (in_valid) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (fill_cnt != CNT_W'(DEPTH)) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Write port of the buffer memory.
    always_ff @(posedge clk) begin
        if (in_valid) mem[wr_ptr] <= in_sample;
    end

    // Registered read port with delay-0 forwarding and zero for unwritten entries.
    always_ff @(posedge clk) begin
        if (!rst_n)              rd_q <= '0;
        else if (in_valid) begin
            if (dly_q == '0)        rd_q <= in_sample;
            else if (!entry_written) rd_q <= '0;
            else                    rd_q <= mem[rd_addr];
        end
    end

    // R3: zero delay forwards the sample accepted in the previous cycle.
    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dly_q == '0) |=> (rd_q == $past(in_sample)));

    // R5: a delay reaching before reset yields zero.
    p_unwritten_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ({1'b0, dly_q} > fill_cnt)) |=> (rd_q == '0));

    // R4: pointer wraps from the last entry back to entry 0.
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wr_ptr == PTR_W'(DEPTH - 1)) |=> (wr_ptr == '0));

    // R8: no accepted sample, no pointer movement.
    p_hold_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_ptr));

    // R7: delay changes only under the load strobe.
    p_dly_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_load |=> $stable(dly_q));

endmodule

// File: rtl/dsc_sum_tree.sv
// Module: sign-extends CH_N samples and adds them combinationally.
// Assumes SUM_W >= SMP_W + clog2(CH_N) so the result cannot overflow.
module dsc_sum_tree #(
    parameter int CH_N  = 4,
    parameter int SMP_W = 10,
    localparam int SUM_W = SMP_W + $clog2(CH_N)
) (
    input  logic [CH_N*SMP_W-1:0] terms,
    output logic [SUM_W-1:0]      total
);

    logic [SUM_W-1:0] partial [CH_N+1];

    assign partial[0] = '0;

    // One adder stage per channel, each adding a sign-extended term.
    for (genvar c = 0; c < CH_N; c++) begin : g_acc
        logic [SMP_W-1:0] t;
        assign t              = terms[c*SMP_W +: SMP_W];
        assign partial[c + 1] = partial[c] + {{(SUM_W-SMP_W){t[SMP_W-1]}}, t};
    end

    assign total = partial[CH_N];

endmodule

// File: rtl/dsc_combiner.sv
// Module: top of the four-channel delay-and-sum combiner.
// Instantiates one delay line per channel, sums the delayed samples and
// raises out_valid once every buffer is primed. One cycle input to output.
module dsc_combiner
    import dsc_pkg::*;
#(
    parameter int N_CH   = CH_N,
    parameter int S_W    = SMP_W,
    parameter int DEPTH  = BUF_DEPTH,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int SUM_W = S_W + $clog2(N_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [N_CH*S_W-1:0] in_samples,
    input  logic               dly_load,
    input  logic [N_CH*PTR_W-1:0] dly_value,
    output logic [SUM_W-1:0]   out_sum,
    output logic               out_valid
);

    logic [N_CH*S_W-1:0] delayed;
    logic [N_CH-1:0]     ch_primed;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dsc_delay_line #(.SMP_W(S_W), .DEPTH(DEPTH)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_sample (in_samples[c*S_W +: S_W]),
            .dly_load  (dly_load),
            .dly_value (dly_value[c*PTR_W +: PTR_W]),
            .rd_q      (delayed[c*S_W +: S_W]),
            .primed    (ch_primed[c])
        );
    end

    dsc_sum_tree #(.CH_N(N_CH), .SMP_W(S_W)) u_sum (
        .terms (delayed),
        .total (out_sum)
    );

    // Valid follows an accepted sample by one cycle once all buffers are primed.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid && (&ch_primed);
    end

    // R6: a valid output always follows an accepted sample.
    p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R8: an idle input cycle gives no valid output next cycle.
    p_idle_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/dsc_combiner_tb.sv
module dsc_combiner_tb;
    localparam int CLK_P = 10;
    localparam int HMAX  = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [39:0] in_samples;
    logic        dly_load;
    logic [23:0] dly_value;
    logic [11:0] out_sum;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int n_smp = 0;
    int cur_d [4];
    logic [9:0] hist [4][HMAX];

    always #(CLK_P/2) clk = ~clk;

    dsc_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .dly_load(dly_load), .dly_value(dly_value),
        .out_sum(out_sum), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at sample %0d", req, act, exp, n_smp);
        end
    endtask

    function automatic logic [23:0] pack_d(input int a, input int b, input int c, input int d);
        return {d[5:0], c[5:0], b[5:0], a[5:0]};
    endfunction

    // One input cycle; called just after a falling edge.
    task automatic step(input bit v, input logic [39:0] s, input bit ld,
                        input logic [23:0] dv, input string tag);
        int    esum = 0;
        bit    unw  = 0;
        bit    allz = 1;
        bit    has63 = 0;
        bit    ev;
        string t;
        in_valid = v; in_samples = s; dly_load = ld; dly_value = dv;
        if (v) begin
            for (int c = 0; c < 4; c++) begin
                hist[c][n_smp] = s[c*10 +: 10];
                if (cur_d[c] != 0) allz = 0;
                if (cur_d[c] == 63) has63 = 1;
                if (cur_d[c] <= n_smp) esum += int'($signed(hist[c][n_smp - cur_d[c]]));
                else unw = 1;
            end
        end
        ev = v && (n_smp >= 63);
        @(posedge clk);
        #(CLK_P/4);
        if (ld) for (int c = 0; c < 4; c++) cur_d[c] = int'(dv[c*6 +: 6]);
        check(v ? "R6" : "R8", {11'd0, out_valid}, {11'd0, ev});
        if (v) begin
            if (tag != "")   t = tag;
            else if (unw)    t = "R5";
            else if (has63)  t = "R4";
            else if (allz)   t = "R3";
            else             t = "R2";
            check(t, out_sum, esum[11:0]);
            n_smp++;
        end
        @(negedge clk);
    endtask

    function automatic logic [39:0] rnd_s();
        return {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
    endfunction

    initial begin
        #(CLK_P*200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < 4; c++) cur_d[c] = 0;
        rst_n = 1'b0; in_valid = 0; in_samples = '0; dly_load = 0; dly_value = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_P/4);
        // R1: reset state
        check("R1", {11'd0, out_valid}, 12'd0);
        check("R1", out_sum, 12'd0);
        @(negedge clk);

        // Delay 0 on all channels: straight through (R3).
        for (int i = 0; i < 8; i++) step(1, rnd_s(), 0, '0, "");
        // Load in a sample cycle: this sample keeps old delays (R7).
        step(1, rnd_s(), 1, pack_d(5, 17, 40, 63), "R7");
        // Early outputs reach before reset (R5), valid rises at sample 63 (R6).
        for (int i = 0; i < 90; i++) step(1, rnd_s(), 0, '0, "");
        // Gaps: no write, no advance (R8).
        for (int i = 0; i < 20; i++) step(i % 3 != 0, rnd_s(), 0, '0, "");
        // dly_value toggling without load is ignored (R7).
        for (int i = 0; i < 20; i++) step(1, rnd_s(), 0, 24'($urandom()), "R7");
        // Max delay on all channels, long run across many wraps (R4).
        step(1, rnd_s(), 1, pack_d(63, 63, 63, 63), "");
        for (int i = 0; i < 200; i++) step(1, rnd_s(), 0, '0, "R4");
        // Random delays, reloads and gaps.
        for (int i = 0; i < 1000; i++) begin
            bit ld = (i % 25 == 0);
            step(($urandom() % 10) != 0, rnd_s(), ld, 24'($urandom()), "");
        end
        // Extremes (R9).
        step(1, rnd_s(), 1, '0, "");
        for (int i = 0; i < 2; i++) step(1, {4{10'h200}}, 0, '0, "R9");
        for (int i = 0; i < 2; i++) step(1, {4{10'h1FF}}, 0, '0, "R9");
        check("R9", out_sum, 12'd2044);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule